// File: doc/BRIEF.md
# Two-Bank Input Gamma Lookup Table

This block maps each 8-bit colour component of a pixel stream through a per-channel table of 256 twelve-bit unsigned fractions (0.12 fixed point). Two complete copies of the table exist, bank A and bank B. One bank can be live for lookups while the host fills the other, and a single mode write then moves lookups to the freshly loaded bank.

The host loads entries through one sequential colour port. It first writes a start index. Each later write carries one channel value. The target channel rotates red, then green, then blue, and after blue the index moves up by one. A three-bit write mask chooses which channels are actually stored. A channel that is masked off still uses up its turn in the rotation. A bank-select bit chooses which bank receives the writes. A status code reports which bank is live, and it also carries the state of a neighbouring unit, which arrives on a plain input.

Pixels enter and leave on valid/ready handshakes. A pixel is accepted when `s_valid` and `s_ready` are both high. Its result appears one cycle later and stays stable until `m_ready` takes it. `s_ready` is high whenever the output register is empty or is being drained in the same cycle, so a stalled output also stops the input.

Top module: `gamma_tab`

## Requirements
- R1: After reset `m_valid` is 0 and `lut_status` is 0. The lookup mode is bypass. The loader points at index 0, red channel, so a first sequential write without an index write lands in red entry 0.
- R2: In lookup mode 0 or 1, each output channel is its 8-bit input placed in bits 11:4, with bits 3:0 zero.
- R3: In mode 2 each output channel is the bank A entry of that channel at the input index. In mode 3 it is the bank B entry. Channel c occupies bits 8c+7:8c of `s_pix` and 12c+11:12c of `m_pix`, with red c=0, green c=1 and blue c=2.
- R4: A pixel accepted on one clock edge is presented with `m_valid` high right after the next edge. The mode used is the one in force when the pixel is accepted.
- R5: `s_ready` equals `!m_valid || m_ready`. While `m_valid` is high and `m_ready` is low, `m_pix` and `m_valid` hold.
- R6: An index write sets the load pointer to `cfg_idx_val` and the channel to red. A sequential write in the same cycle is dropped.
- R7: Sequential writes go to red, green and blue in turn. After blue the index increments, and it wraps from 255 to 0.
- R8: Mask bit 0 enables red, bit 1 green and bit 2 blue. A write whose channel is masked off leaves the table unchanged but still advances the rotation.
- R9: `cfg_bank_sel` = 0 writes bank A and 1 writes bank B. Writes to one bank never change lookups from the other.
- R10: `lut_status` is 0 in bypass. With bank A live it is 1, 3 or 4 for neighbour state 0 (or 3), 1 and 2. With bank B live it is 2, 5 or 6 for the same neighbour states.
- R11: When a lookup and a write address the same entry in the same cycle, the lookup returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_idx_wr | input | 1 | Load-pointer write strobe |
| cfg_idx_val | input | 8 | Start index for loading |
| cfg_seq_wr | input | 1 | Sequential colour write strobe |
| cfg_seq_data | input | 12 | Entry value for the current channel |
| cfg_wmask | input | 3 | Channel write mask (bit0 red, bit1 green, bit2 blue) |
| cfg_bank_sel | input | 1 | Load target bank: 0 A, 1 B |
| cfg_mode_wr | input | 1 | Lookup-mode write strobe |
| cfg_mode_val | input | 2 | Lookup mode: 0/1 bypass, 2 bank A, 3 bank B |
| nb_state | input | 2 | Neighbour unit state: 0 idle, 1 ROM A, 2 ROM B |
| lut_status | output | 3 | Live-bank status code |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Input pixel ready |
| s_pix | input | 24 | Input pixel, red in the low byte |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Output pixel ready |
| m_pix | output | 36 | Output pixel, red in the low 12 bits |

## Verification
A rotation counter or load pointer that is off by one shows up as lookups that return a neighbouring channel's or index's entry. This appears on the first result that reads the corrupted index, one cycle after that pixel is accepted. A wrong bank choice or a stale mode register shows at once as data from the other bank, or as a status code that does not match. A stall register that fails to hold shows as `m_pix` changing, or a pixel disappearing, in the same cycle that `m_ready` is low. A reference model that runs every cycle catches each of these on the exact cycle it occurs.

// File: rtl/gamma_tab_pkg.sv
package gamma_tab_pkg;

  localparam int unsigned CH_N   = 3;
  localparam int unsigned BANK_N = 2;

  typedef enum logic [1:0] {
    CH_RED = 2'd0,
    CH_GRN = 2'd1,
    CH_BLU = 2'd2
  } chan_e;

  typedef enum logic [1:0] {
    LK_BYPASS = 2'd0,
    LK_RSVD   = 2'd1,
    LK_BANK_A = 2'd2,
    LK_BANK_B = 2'd3
  } lk_mode_e;

  typedef enum logic [1:0] {
    NB_IDLE  = 2'd0,
    NB_ROM_A = 2'd1,
    NB_ROM_B = 2'd2,
    NB_RSVD  = 2'd3
  } nb_state_e;

  // Live-bank code folded together with the neighbour's state
  function automatic logic [2:0] status_code(lk_mode_e m, nb_state_e n);
    logic [2:0] code;
    code = 3'd0;
    case (m)
      LK_BANK_A: begin
        case (n)
          NB_ROM_A: code = 3'd3;
          NB_ROM_B: code = 3'd4;
          default:  code = 3'd1;
        endcase
      end
      LK_BANK_B: begin
        case (n)
          NB_ROM_A: code = 3'd5;
          NB_ROM_B: code = 3'd6;
          default:  code = 3'd2;
        endcase
      end
      default: code = 3'd0;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/gamma_tab_loader.sv
module gamma_tab_loader
  import gamma_tab_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned ENT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_wr,
  input  logic [IDX_W-1:0]  idx_val,
  input  logic              seq_wr,
  input  logic [ENT_W-1:0]  seq_data,
  input  logic [CH_N-1:0]   wmask,
  input  logic              bank_sel,
  output logic [CH_N-1:0]   wr_ch_en,
  output logic              wr_bank,
  output logic [IDX_W-1:0]  wr_addr,
  output logic [ENT_W-1:0]  wr_data,
  output logic [IDX_W-1:0]  ptr_o,
  output logic [1:0]        ch_o,
  output logic              go_o
);

  logic [IDX_W-1:0] ptr_q;
  chan_e            ch_q;
  logic             seq_go;

  // an index write in the same cycle wins over a colour write
  assign seq_go = seq_wr && !idx_wr;

  always_comb begin
    wr_ch_en = '0;
    case (ch_q)
      CH_RED:  wr_ch_en[0] = seq_go && wmask[0];
      CH_GRN:  wr_ch_en[1] = seq_go && wmask[1];
      CH_BLU:  wr_ch_en[2] = seq_go && wmask[2];
      default: wr_ch_en = '0;
    endcase
  end

  assign wr_bank = bank_sel;
  assign wr_addr = ptr_q;
  assign wr_data = seq_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      ch_q  <= CH_RED;
    end else if (idx_wr) begin
      ptr_q <= idx_val;
      ch_q  <= CH_RED;
    end else if (seq_go) begin
      case (ch_q)
        CH_RED:  ch_q <= CH_GRN;
        CH_GRN:  ch_q <= CH_BLU;
        default: begin
          ch_q  <= CH_RED;
          ptr_q <= ptr_q + IDX_W'(1);
        end
      endcase
    end
  end

  assign ptr_o = ptr_q;
  assign ch_o  = ch_q;
  assign go_o  = seq_go;

endmodule

// File: rtl/gamma_tab_ram.sv
module gamma_tab_ram #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned ENT_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [ENT_W-1:0]  wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [ENT_W-1:0]  rdata
);

  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [ENT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read returns the pre-write contents on a same-cycle hit
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/gamma_tab_stage.sv
module gamma_tab_stage
  import gamma_tab_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned ENT_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic [CH_N*IDX_W-1:0]   s_pix,
  input  lk_mode_e                mode_i,
  input  logic [CH_N*ENT_W-1:0]   rd_a,
  input  logic [CH_N*ENT_W-1:0]   rd_b,
  output logic                    rd_en,
  output logic                    m_valid,
  input  logic                    m_ready,
  output logic [CH_N*ENT_W-1:0]   m_pix,
  output lk_mode_e                sel_q
);

  localparam int unsigned PAD = ENT_W - IDX_W;

  logic                  take;
  logic [CH_N*IDX_W-1:0] pix_q;

  assign s_ready = !m_valid || m_ready;
  assign take    = s_valid && s_ready;
  assign rd_en   = take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      sel_q   <= LK_BYPASS;
      pix_q   <= '0;
    end else begin
      if (take)         m_valid <= 1'b1;
      else if (m_ready) m_valid <= 1'b0;
      if (take) begin
        sel_q <= mode_i;
        pix_q <= s_pix;
      end
    end
  end

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    logic [ENT_W-1:0] ch_out;
    always_comb begin
      case (sel_q)
        LK_BANK_A: ch_out = rd_a[c*ENT_W +: ENT_W];
        LK_BANK_B: ch_out = rd_b[c*ENT_W +: ENT_W];
        default:   ch_out = {pix_q[c*IDX_W +: IDX_W], {PAD{1'b0}}};
      endcase
    end
    assign m_pix[c*ENT_W +: ENT_W] = ch_out;
  end

endmodule

// File: rtl/gamma_tab.sv
module gamma_tab
  import gamma_tab_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned ENT_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_idx_wr,
  input  logic [IDX_W-1:0]        cfg_idx_val,
  input  logic                    cfg_seq_wr,
  input  logic [ENT_W-1:0]        cfg_seq_data,
  input  logic [2:0]              cfg_wmask,
  input  logic                    cfg_bank_sel,
  input  logic                    cfg_mode_wr,
  input  logic [1:0]              cfg_mode_val,
  input  logic [1:0]              nb_state,
  output logic [2:0]              lut_status,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic [3*IDX_W-1:0]      s_pix,
  output logic                    m_valid,
  input  logic                    m_ready,
  output logic [3*ENT_W-1:0]      m_pix
);

  localparam int unsigned OUT_W = CH_N * ENT_W;

  lk_mode_e               mode_q;
  lk_mode_e               sel_q;
  logic [CH_N-1:0]        ld_we;
  logic                   ld_bank;
  logic [IDX_W-1:0]       ld_addr;
  logic [ENT_W-1:0]       ld_data;
  logic [IDX_W-1:0]       ld_ptr;
  logic [1:0]             ld_ch;
  logic                   ld_go;
  logic                   rd_en;
  logic [BANK_N-1:0][OUT_W-1:0] rd_bank;

  always_ff @(posedge clk) begin
    if (!rst_n)           mode_q <= LK_BYPASS;
    else if (cfg_mode_wr) mode_q <= lk_mode_e'(cfg_mode_val);
  end

  assign lut_status = status_code(mode_q, nb_state_e'(nb_state));

  gamma_tab_loader #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_load (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_wr   (cfg_idx_wr),
    .idx_val  (cfg_idx_val),
    .seq_wr   (cfg_seq_wr),
    .seq_data (cfg_seq_data),
    .wmask    (cfg_wmask),
    .bank_sel (cfg_bank_sel),
    .wr_ch_en (ld_we),
    .wr_bank  (ld_bank),
    .wr_addr  (ld_addr),
    .wr_data  (ld_data),
    .ptr_o    (ld_ptr),
    .ch_o     (ld_ch),
    .go_o     (ld_go)
  );

  for (genvar b = 0; b < BANK_N; b++) begin : g_bank
    for (genvar c = 0; c < CH_N; c++) begin : g_ch
      logic we_bc;
      assign we_bc = ld_we[c] && (ld_bank == b[0]);
      gamma_tab_ram #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_ram (
        .clk   (clk),
        .we    (we_bc),
        .waddr (ld_addr),
        .wdata (ld_data),
        .re    (rd_en),
        .raddr (s_pix[c*IDX_W +: IDX_W]),
        .rdata (rd_bank[b][c*ENT_W +: ENT_W])
      );
    end
  end

  gamma_tab_stage #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .s_pix   (s_pix),
    .mode_i  (mode_q),
    .rd_a    (rd_bank[0]),
    .rd_b    (rd_bank[1]),
    .rd_en   (rd_en),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_pix   (m_pix),
    .sel_q   (sel_q)
  );

endmodule

// File: rtl/gamma_tab_chk.sv
module gamma_tab_chk #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned ENT_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic              s_ready,
  input logic              m_valid,
  input logic              m_ready,
  input logic [3*ENT_W-1:0] m_pix,
  input logic [2:0]        lut_status,
  input logic [1:0]        sel_q,
  input logic [IDX_W-1:0]  ld_ptr,
  input logic [1:0]        ld_ch,
  input logic              ld_go
);

  localparam int unsigned PAD = ENT_W - IDX_W;

  AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready |=> m_valid); // R4

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_pix)); // R5

  AST_BYPASS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !sel_q[1] |-> (m_pix[0 +: PAD] == '0) && (m_pix[ENT_W +: PAD] == '0)
                              && (m_pix[2*ENT_W +: PAD] == '0)); // R2

  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    lut_status != 3'd7); // R10

  AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ch != 2'd3); // R7

  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ld_go && (ld_ch == 2'd2) |=> ld_ptr == IDX_W'($past(ld_ptr) + 1'b1)); // R7

  AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_go && (ld_ch != 2'd2) |=> $stable(ld_ptr)); // R7

endmodule

bind gamma_tab gamma_tab_chk #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .s_valid    (s_valid),
  .s_ready    (s_ready),
  .m_valid    (m_valid),
  .m_ready    (m_ready),
  .m_pix      (m_pix),
  .lut_status (lut_status),
  .sel_q      (sel_q),
  .ld_ptr     (ld_ptr),
  .ld_ch      (ld_ch),
  .ld_go      (ld_go)
);

// File: tb/gamma_tab_bench.sv
`timescale 1ns/1ps
module gamma_tab_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_idx_wr = 1'b0;
  logic [7:0]  cfg_idx_val = '0;
  logic        cfg_seq_wr = 1'b0;
  logic [11:0] cfg_seq_data = '0;
  logic [2:0]  cfg_wmask = 3'd7;
  logic        cfg_bank_sel = 1'b0;
  logic        cfg_mode_wr = 1'b0;
  logic [1:0]  cfg_mode_val = '0;
  logic [1:0]  nb_state = '0;
  logic [2:0]  lut_status;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [23:0] s_pix = '0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [35:0] m_pix;

  always #2 clk = ~clk;

  gamma_tab u_gamma_tab (
    .clk(clk), .rst_n(rst_n),
    .cfg_idx_wr(cfg_idx_wr), .cfg_idx_val(cfg_idx_val),
    .cfg_seq_wr(cfg_seq_wr), .cfg_seq_data(cfg_seq_data),
    .cfg_wmask(cfg_wmask), .cfg_bank_sel(cfg_bank_sel),
    .cfg_mode_wr(cfg_mode_wr), .cfg_mode_val(cfg_mode_val),
    .nb_state(nb_state), .lut_status(lut_status),
    .s_valid(s_valid), .s_ready(s_ready), .s_pix(s_pix),
    .m_valid(m_valid), .m_ready(m_ready), .m_pix(m_pix)
  );

  int    checks = 0;
  int    failures = 0;
  int    cyc_cnt = 0;
  bit    bp_on = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // behavioural reference model
  int mmem [2][3][256];
  int mptr, mch, mmode;
  bit mov;
  int mout [3];

  function automatic int exp_status(int md, int nb);
    if (md == 2) return (nb == 1) ? 3 : (nb == 2) ? 4 : 1;
    if (md == 3) return (nb == 1) ? 5 : (nb == 2) ? 6 : 2;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mptr = 0; mch = 0; mmode = 0; mov = 1'b0;
    end else begin
      if (s_valid && (!mov || m_ready)) begin
        mov = 1'b1;
        for (int c = 0; c < 3; c++) begin
          int px;
          px = int'(s_pix[c*8 +: 8]);
          if (mmode == 2)      mout[c] = mmem[0][c][px];
          else if (mmode == 3) mout[c] = mmem[1][c][px];
          else                 mout[c] = px * 16;
        end
      end else if (m_ready) begin
        mov = 1'b0;
      end
      if (cfg_mode_wr) mmode = int'(cfg_mode_val);
      if (cfg_idx_wr) begin
        mptr = int'(cfg_idx_val); mch = 0;
      end else if (cfg_seq_wr) begin
        if (cfg_wmask[mch]) mmem[cfg_bank_sel][mch][mptr] = int'(cfg_seq_data);
        if (mch == 2) begin mch = 0; mptr = (mptr + 1) % 256; end
        else mch = mch + 1;
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5", "s_ready", int'(s_ready), int'(!mov || m_ready));
      chk("R4", "m_valid", int'(m_valid), int'(mov));
      chk("R10", "lut_status", int'(lut_status), exp_status(mmode, int'(nb_state)));
      if (mov && m_valid) begin
        for (int c = 0; c < 3; c++)
          chk(cur_req, "m_pix channel", int'(m_pix[c*12 +: 12]), mout[c]);
      end
    end
  end

  always @(posedge clk) begin
    #0.5;
    m_ready = bp_on ? (cyc_cnt[0] ^ cyc_cnt[2]) : 1'b1;
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt == 150000 && !done) begin
      failures++;
      checks++;
      $display("FAIL R4 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic seqw(input logic [11:0] d);
    cfg_seq_wr = 1'b1; cfg_seq_data = d; cyc(); cfg_seq_wr = 1'b0;
  endtask

  task automatic idxw(input logic [7:0] v);
    cfg_idx_wr = 1'b1; cfg_idx_val = v; cyc(); cfg_idx_wr = 1'b0;
  endtask

  task automatic modew(input logic [1:0] v);
    cfg_mode_wr = 1'b1; cfg_mode_val = v; cyc(); cfg_mode_wr = 1'b0;
  endtask

  task automatic px(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    bit acc;
    s_valid = 1'b1; s_pix = {b, g, r};
    do begin acc = s_ready; cyc(); end while (!acc);
    s_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) cyc();
  endtask

  function automatic logic [11:0] pat(int bk, int c, int i);
    return 12'((i * 37 + c * 1111 + bk * 523 + 5) & 12'hFFF);
  endfunction

  task automatic sweep();
    px(8'd0, 8'd0, 8'd0);
    px(8'd255, 8'd255, 8'd255);
    px(8'd1, 8'd128, 8'd254);
    px(8'd77, 8'd3, 8'd200);
    drain();
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "m_valid after reset", int'(m_valid), 0);
    chk("R1", "status after reset", int'(lut_status), 0);
    chk("R1", "s_ready after reset", int'(s_ready), 1);
    #1;

    // R1 / R7 / R9: fill bank A with no index write, then bank B via wrap
    cur_req = "R7";
    cfg_bank_sel = 1'b0;
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++) seqw(pat(0, c, i));
    cfg_bank_sel = 1'b1;
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++) seqw(pat(1, c, i));

    // R2: both bypass codes
    cur_req = "R2";
    sweep();
    modew(2'd1);
    sweep();

    // R3: bank A then bank B
    cur_req = "R3";
    modew(2'd2);
    sweep();
    modew(2'd3);
    sweep();

    // R10: neighbour states across modes
    cur_req = "R10";
    for (int n = 0; n < 4; n++) begin
      nb_state = 2'(n); cyc();
      modew(2'd2); cyc();
      modew(2'd0); cyc();
      modew(2'd3); cyc();
    end
    nb_state = 2'd0;

    // R5: back-pressure while streaming
    cur_req = "R5";
    bp_on = 1'b1;
    for (int i = 0; i < 24; i++) px(8'(i * 11), 8'(i * 7 + 3), 8'(255 - i));
    bp_on = 1'b0;
    drain();

    // R4: back-to-back accepts with mode switch between them
    cur_req = "R4";
    px(8'd9, 8'd9, 8'd9);
    cfg_mode_wr = 1'b1; cfg_mode_val = 2'd2;
    px(8'd9, 8'd9, 8'd9);
    cfg_mode_wr = 1'b0;
    px(8'd9, 8'd9, 8'd9);
    drain();

    // R8: masked green is consumed; next write lands on index 11 red
    cur_req = "R8";
    cfg_bank_sel = 1'b0;
    idxw(8'd10);
    cfg_wmask = 3'b101;
    seqw(12'h111); seqw(12'h222); seqw(12'h333);
    cfg_wmask = 3'b111;
    seqw(12'h444);
    px(8'd10, 8'd10, 8'd10);
    px(8'd11, 8'd11, 8'd11);
    drain();

    // R6: index write and colour write together
    cur_req = "R6";
    cfg_idx_wr = 1'b1; cfg_idx_val = 8'd40;
    cfg_seq_wr = 1'b1; cfg_seq_data = 12'hABC;
    cyc();
    cfg_idx_wr = 1'b0; cfg_seq_wr = 1'b0;
    seqw(12'h123);
    px(8'd40, 8'd40, 8'd40);
    px(8'd41, 8'd41, 8'd41);
    drain();

    // R9: writes to bank B do not disturb bank A lookups
    cur_req = "R9";
    cfg_bank_sel = 1'b1;
    idxw(8'd20);
    seqw(12'hF00); seqw(12'h0F0); seqw(12'h00F);
    px(8'd20, 8'd20, 8'd20);
    drain();
    modew(2'd3);
    px(8'd20, 8'd20, 8'd20);
    drain();

    // R11: same-cycle write and lookup of one entry
    cur_req = "R11";
    modew(2'd2);
    cfg_bank_sel = 1'b0;
    idxw(8'd77);
    cfg_seq_wr = 1'b1; cfg_seq_data = 12'h5A5;
    s_valid = 1'b1; s_pix = {8'd77, 8'd77, 8'd77};
    cyc();
    cfg_seq_wr = 1'b0; s_valid = 1'b0;
    drain();
    px(8'd77, 8'd77, 8'd77);
    drain();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule